// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

A sixteen-pin general-purpose I/O port. Each pin has a direction bit, an output latch bit, an open-drain bit and an analog/digital select bit. All four are held in a register file on a simple single-cycle register bus. The block drives an output-enable and an output value to every pad. It registers the pad inputs through one flip-flop stage. The bus reads back the direction register, the latch and the sampled pin state, each separately.

The pin-view read returns what the pads actually show, one clock late. It does not return the latch. Pins in analog mode read as zero. The bus offers plain writes plus bit-set and bit-clear operations. A bit operation at the pin-view address merges its mask with the sampled pins. The same operation at the latch address merges with the latch. Software should therefore use the latch address for back-to-back bit updates.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high and after its release, all pins are inputs (direction reads 16'hFFFF), the latch and the open-drain register read 0, the analog-select register holds all zeros, and `pad_oe` is 0.
- R2: A direction bit of 0 makes the pin an output, so `pad_oe` is 1 and `pad_out` equals the latch bit. A direction bit of 1 makes it an input, with `pad_oe` at 0.
- R3: For an output pin with its open-drain bit at 1, a latch bit of 0 drives the pad low (`pad_oe`=1, `pad_out`=0). A latch bit of 1 releases the pad (`pad_oe`=0).
- R4: A select bit of 0 puts the pin in analog mode, and reset leaves every analog-capable pin there. The default analog-capable pins are 0 to 7. A pin-view read returns 0 on analog pins whatever the pad level. `pad_ana` flags those pins. Select bits of pins that are not analog-capable read back as 1.
- R5: A pin-view read returns the pad level registered on the previous clock edge, not the latch. A pad change is seen only after one clock edge.
- R6: A write to the pin-view offset loads the latch exactly as a write to the latch offset does.
- R7: Set and clear operations at the pin-view offset compute the new latch from the analog-masked sampled pins. Two such operations on consecutive cycles therefore lose the first one's update.
- R8: Set and clear operations at the latch offset compute from the latch, so consecutive operations both take effect.
- R9: Register offsets are direction 0, pin-view 1, latch 2, open-drain 3 and analog-select 4. Bus operation codes are 0 write, 1 set, 2 clear and 3 no effect. Offsets 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register operation strobe |
| bus_op | input | 2 | Operation: 0 write, 1 set, 2 clear, 3 none |
| bus_addr | input | 3 | Register offset, also selects read data |
| bus_wdata | input | 16 | Write data or bit mask |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Pad output enable per pin |
| pad_out | output | 16 | Pad output value per pin |
| pad_ana | output | 16 | Pin is in analog mode |

## Verification
The bench loops each pad back through a model that gives either the driven value or an external level. It then sweeps all eight direction/open-drain/latch combinations across every bit position. A design that mixed up the open-drain release would drive a high where the bench expects a released pad. The bench reads the pin view in the same cycle as a pad change and again one cycle later. A design without the sampling register, or one that returned the latch, fails there. Consecutive set operations at the pin-view offset must lose the first update, while the same pair at the latch offset keeps both. A design that used the wrong merge source therefore fails one half of that pair. The bench also checks analog masking at reset, and it checks that writes to undefined offsets change nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR = 3'd0,
        REG_PIN = 3'd1,
        REG_LAT = 3'd2,
        REG_ODC = 3'd3,
        REG_ANA = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic [GPIO_W-1:0] dir;   // 1 = input
        logic [GPIO_W-1:0] lat;   // output latch
        logic [GPIO_W-1:0] odc;   // 1 = open-drain
        logic [GPIO_W-1:0] ana;   // 0 = analog
    } port_cfg_t;

    function automatic logic [GPIO_W-1:0] apply_op(
        input logic [GPIO_W-1:0] base,
        input logic [GPIO_W-1:0] data,
        input bus_op_e           op
    );
        case (op)
            OP_WRITE: apply_op = data;
            OP_SET:   apply_op = base | data;
            OP_CLR:   apply_op = base & ~data;
            default:  apply_op = base;
        endcase
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic [GPIO_W-1:0] wdata,
    input  logic [GPIO_W-1:0] pin_view,
    output port_cfg_t         cfg
);

    bus_op_e op_e;
    assign op_e = bus_op_e'(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.dir <= '1;
            cfg.lat <= '0;
            cfg.odc <= '0;
            cfg.ana <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_DIR: cfg.dir <= apply_op(cfg.dir, wdata, op_e);
                REG_PIN: cfg.lat <= apply_op(pin_view, wdata, op_e);
                REG_LAT: cfg.lat <= apply_op(cfg.lat, wdata, op_e);
                REG_ODC: cfg.odc <= apply_op(cfg.odc, wdata, op_e);
                REG_ANA: cfg.ana <= apply_op(cfg.ana, wdata, op_e);
                default: ;
            endcase
        end
    end

    AST_PIN_WRITE_LOADS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_PIN && op == OP_WRITE) |=> cfg.lat == $past(wdata)); // R6

    AST_LAT_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_LAT && op == OP_SET)
        |=> cfg.lat == ($past(cfg.lat) | $past(wdata))); // R8

    AST_LAT_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_LAT && op == OP_CLR)
        |=> cfg.lat == ($past(cfg.lat) & ~$past(wdata))); // R8

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter logic [GPIO_W-1:0] ANA_PINS = 16'h00FF
) (
    input  port_cfg_t         cfg,
    output logic [GPIO_W-1:0] pad_oe,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_ana
);

    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        always_comb begin
            if (cfg.dir[i]) begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
            end else if (cfg.odc[i]) begin
                pad_oe[i]  = ~cfg.lat[i];
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = cfg.lat[i];
            end
        end
        assign pad_ana[i] = ANA_PINS[i] & ~cfg.ana[i];
    end

endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample
    import gpio_pkg::*;
#(
    parameter logic [GPIO_W-1:0] ANA_PINS = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] pad_in,
    input  logic [GPIO_W-1:0] ana_sel,
    output logic [GPIO_W-1:0] pin_view
);

    logic [GPIO_W-1:0] pin_q;
    logic [GPIO_W-1:0] dig_mask;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pad_in;
    end

    assign dig_mask = ana_sel | ~ANA_PINS;
    assign pin_view = pin_q & dig_mask;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter logic [GPIO_W-1:0] ANA_PINS = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pad_in,
    output logic [GPIO_W-1:0] pad_oe,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_ana
);

    port_cfg_t         cfg;
    logic [GPIO_W-1:0] pin_view;

    gpio_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .op       (bus_op),
        .wdata    (bus_wdata),
        .pin_view (pin_view),
        .cfg      (cfg)
    );

    gpio_pad_ctrl #(.ANA_PINS(ANA_PINS)) u_pads (
        .cfg     (cfg),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_ana (pad_ana)
    );

    gpio_in_sample #(.ANA_PINS(ANA_PINS)) u_sample (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .ana_sel  (cfg.ana),
        .pin_view (pin_view)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_DIR: bus_rdata = cfg.dir;
            REG_PIN: bus_rdata = pin_view;
            REG_LAT: bus_rdata = cfg.lat;
            REG_ODC: bus_rdata = cfg.odc;
            REG_ANA: bus_rdata = cfg.ana | ~ANA_PINS;
            default: bus_rdata = '0;
        endcase
    end

    AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & cfg.dir) == '0); // R2

    AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & cfg.odc) == '0); // R3

    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_PIN) |-> (bus_rdata & pad_ana) == '0); // R4

    AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > REG_ANA) |-> bus_rdata == '0); // R9

endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;

    localparam logic [15:0] ANA = 16'h00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_op = 2'd0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in, pad_oe, pad_out, pad_ana;
    logic [15:0] ext = 16'h0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // pad model: driven value when enabled, else the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ana(pad_ana)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic op(input logic [2:0] a, input logic [1:0] o, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_op = o; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] d, o, l, eoe, eout, epin;
        repeat (3) @(negedge clk);
        // R1 reset state, observed while reset is held
        check("R1 oe in reset", pad_oe, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        rd(3'd0, v); check("R1 dir", v, 16'hFFFF);
        rd(3'd2, v); check("R1 lat", v, 16'h0000);
        rd(3'd3, v); check("R1 odc", v, 16'h0000);
        rd(3'd4, v); check("R1 R4 ana readback", v, ~ANA);
        check("R1 oe", pad_oe, 16'h0000);

        // R4 analog pins read zero, flagged on pad_ana
        ext = 16'hFFFF;
        cyc(2);
        rd(3'd1, v); check("R4 analog masked", v, ~ANA);
        check("R4 pad_ana", pad_ana, ANA);
        op(3'd4, 2'd0, 16'hFFFF);
        cyc(1);
        rd(3'd1, v); check("R4 digital after select", v, 16'hFFFF);
        check("R4 pad_ana cleared", pad_ana, 16'h0000);

        // R9 undefined offsets
        for (int a = 5; a < 8; a++) begin
            op(3'(a), 2'd0, 16'hFFFF);
            rd(3'(a), v); check("R9 undefined reads 0", v, 16'h0000);
        end
        rd(3'd0, v); check("R9 dir untouched", v, 16'hFFFF);
        rd(3'd2, v); check("R9 lat untouched", v, 16'h0000);
        rd(3'd3, v); check("R9 odc untouched", v, 16'h0000);
        op(3'd2, 2'd3, 16'hFFFF);
        rd(3'd2, v); check("R9 op 3 no effect", v, 16'h0000);

        // R5 latency and pin-not-latch
        ext = 16'h0000;
        cyc(2);
        ext = 16'h5A3C;
        rd(3'd1, v); check("R5 not yet sampled", v, 16'h0000);
        @(negedge clk);
        rd(3'd1, v); check("R5 sampled after one edge", v, 16'h5A3C);

        // R2/R3 sweep over every combination at every bit
        for (int s = 0; s < 8; s++) begin
            d = '0; o = '0; l = '0;
            for (int i = 0; i < 16; i++) begin
                d[i] = ((i + s) % 8) & 1;
                o[i] = (((i + s) % 8) >> 1) & 1;
                l[i] = (((i + s) % 8) >> 2) & 1;
            end
            ext = 16'hA5C3 ^ (16'(s) * 16'h1111);
            op(3'd0, 2'd0, d);
            op(3'd3, 2'd0, o);
            op(3'd2, 2'd0, l);
            eoe  = ~d & ~(o & l);
            eout = ~d & ~o & l;
            epin = (eoe & eout) | (~eoe & ext);
            check("R2 R3 pad_oe sweep", pad_oe, eoe);
            check("R2 R3 pad_out sweep", pad_out & pad_oe, eout);
            cyc(1);
            rd(3'd1, v); check("R5 pin view sweep", v, epin);
        end

        // R6 write via pin-view offset loads latch
        op(3'd0, 2'd0, 16'h0000);
        op(3'd3, 2'd0, 16'h0000);
        op(3'd1, 2'd0, 16'hC3A5);
        rd(3'd2, v); check("R6 pin write loads latch", v, 16'hC3A5);
        check("R6 pad_out follows", pad_out, 16'hC3A5);

        // R7 consecutive set at pin-view offset loses the first update
        op(3'd2, 2'd0, 16'h0000);
        cyc(2);
        op(3'd1, 2'd1, 16'h0002);
        op(3'd1, 2'd1, 16'h0040);
        rd(3'd2, v); check("R7 back-to-back pin set", v, 16'h0040);
        op(3'd2, 2'd0, 16'h0000);
        cyc(2);
        op(3'd1, 2'd1, 16'h0002);
        cyc(1);
        op(3'd1, 2'd1, 16'h0040);
        rd(3'd2, v); check("R7 spaced pin set", v, 16'h0042);
        // R7 open-drain pin held low externally clears its latch
        op(3'd3, 2'd0, 16'h0001);
        op(3'd2, 2'd0, 16'h0001);
        ext = 16'h0000;
        cyc(2);
        op(3'd1, 2'd1, 16'h0020);
        rd(3'd2, v); check("R7 pin set uses pad level", v, 16'h0020);
        op(3'd2, 2'd0, 16'h000F);
        cyc(2);
        op(3'd1, 2'd2, 16'h0004);
        rd(3'd2, v); check("R7 pin clear uses pad level", v, 16'h000A);

        // R8 consecutive ops at latch offset both take effect
        op(3'd3, 2'd0, 16'h0000);
        op(3'd2, 2'd0, 16'h0000);
        op(3'd2, 2'd1, 16'h0002);
        op(3'd2, 2'd1, 16'h0040);
        rd(3'd2, v); check("R8 back-to-back latch set", v, 16'h0042);
        op(3'd2, 2'd2, 16'h0002);
        op(3'd2, 2'd2, 16'h0040);
        rd(3'd2, v); check("R8 back-to-back latch clear", v, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule